// File: doc/BRIEF.md
# BCH(31,21) Message Word Corrector

This block takes one received 32-bit pager codeword per clock and repairs it. It divides the 31 coded bits by the BCH(31,21) generator to get a 10-bit syndrome. It looks that syndrome up against every single-bit error pattern and every two-adjacent-bit error pattern. If there is a match, it flips the bits that pattern names. In the same cycle it checks even parity over all 32 received bits. The parity check uses the word as it arrived, before any repair.

The result is registered one cycle after the input is accepted. It carries the 20 repaired information bits, a 2-bit correction code and the parity-failure flag, also packed into a single 23-bit word. It also carries the repaired flag bit, which says whether the word is a message or an address/idle word. The downstream logic stops forwarding message output when that flag is 0. A new word can be accepted on every clock.

Top module: `bch_msg_corrector`

## Requirements
- R1: Received word layout: bit 31 is the type flag, bits 30:11 are the 20 information bits, bits 10:1 are the check bits and bit 0 is the even-parity bit. The check bits are the remainder of bits 31:1, taken as a polynomial with bit 31 as the highest power, modulo x^10+x^9+x^8+x^6+x^5+x^3+1. `out_data` carries bits 30:11 after repair.
- R2: A word whose bits 31:1 form a valid codeword is passed through unchanged with `out_fix` = 2'b00.
- R3: An error in any single bit among bits 31:1 is repaired and reported with `out_fix` = 2'b10.
- R4: An error in any two neighbouring bits among bits 31:1 is repaired and reported with `out_fix` = 2'b01.
- R5: A word matching neither pattern, such as two non-neighbouring errors, is reported with `out_fix` = 2'b11. Its data and flag bits are passed on exactly as received.
- R6: `out_perr` is 1 when the XOR of all 32 received bits is 1, computed before repair. An error confined to bit 0 gives `out_fix` = 2'b00, `out_perr` = 1 and unchanged data.
- R7: `out_is_msg` equals the repaired bit 31: 1 for a message word, 0 for an address or idle word.
- R8: `in_ready` is always 1. `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` high, so one word is accepted per clock with one cycle of latency.
- R9: `out_word` packs `out_data` in bits 22:3, `out_fix` in bits 2:1 and `out_perr` in bit 0.
- R10: While reset is held, and until the first word is accepted, `out_valid`, `out_word` and `out_is_msg` are 0.
- R11: In a cycle without `in_valid`, `out_word` and `out_is_msg` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Received word present |
| in_ready | output | 1 | Always high; a word is taken every cycle |
| in_word | input | 32 | Received codeword, type flag in bit 31 |
| out_valid | output | 1 | Result present, one cycle after acceptance |
| out_data | output | 20 | Repaired information bits |
| out_fix | output | 2 | 00 clean, 10 one bit, 01 adjacent pair, 11 not repairable |
| out_perr | output | 1 | Even-parity failure on the received word |
| out_is_msg | output | 1 | Repaired type flag, 1 for message |
| out_word | output | 23 | {out_data, out_fix, out_perr} |

## Verification
A wrong constant in one syndrome column, or in one locator entry, shows up only for the error positions that use it. It appears one cycle later as a wrong `out_fix` code, or as data with a stray or missing bit flip. For that reason every single position and every neighbouring pair is driven at least once, rather than left to random choice. A parity flag taken from the repaired word instead of the received one differs only when a repair happens, so single and pair errors are also checked for their parity result. A bad clock enable on the result register is visible in the first idle cycle, as a change of `out_word` while `in_valid` is low.

// File: rtl/bchfix_pkg.sv
package bchfix_pkg;
  localparam int DATA_W   = 20;
  localparam int CHK_W    = 10;
  localparam int CODE_N   = 1 + DATA_W + CHK_W;
  localparam int WORD_W   = CODE_N + 1;
  localparam int OUT_W    = DATA_W + 3;
  localparam int PAIR_N   = CODE_N - 1;
  localparam logic [CHK_W:0] GEN_POLY = 11'b111_0110_1001;

  typedef enum logic [1:0] {
    FIX_NONE = 2'b00,
    FIX_ADJ  = 2'b01,
    FIX_ONE  = 2'b10,
    FIX_FAIL = 2'b11
  } fix_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    fix_e              fix;
    logic              perr;
  } result_t;

  // remainder of x^k modulo the generator
  function automatic logic [CHK_W-1:0] pow_rem(input int k);
    logic [CHK_W:0] r;
    r = {{CHK_W{1'b0}}, 1'b1};
    for (int j = 0; j < k; j++) begin
      r = r << 1;
      if (r[CHK_W]) r = r ^ GEN_POLY;
    end
    return r[CHK_W-1:0];
  endfunction
endpackage

// File: rtl/bchfix_rst_sync.sv
module bchfix_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_q = chain[STAGES-1];
endmodule

// File: rtl/bchfix_syndrome.sv
module bchfix_syndrome
  import bchfix_pkg::*;
(
  input  logic [CODE_N-1:0] code_i,
  output logic [CHK_W-1:0]  syn_o
);
  logic [CODE_N-1:0][CHK_W-1:0] col;

  for (genvar g = 0; g < CODE_N; g++) begin : g_col
    localparam logic [CHK_W-1:0] KCOL = pow_rem(g);
    assign col[g] = code_i[g] ? KCOL : '0;
  end

  always_comb begin
    syn_o = '0;
    for (int i = 0; i < CODE_N; i++) syn_o = syn_o ^ col[i];
  end
endmodule

// File: rtl/bchfix_locator.sv
module bchfix_locator
  import bchfix_pkg::*;
(
  input  logic [CHK_W-1:0]  syn_i,
  output logic [CODE_N-1:0] flip_o,
  output fix_e              fix_o
);
  logic [CODE_N-1:0] hit1;
  logic [PAIR_N-1:0] hit2;

  for (genvar g = 0; g < CODE_N; g++) begin : g_one
    localparam logic [CHK_W-1:0] KONE = pow_rem(g);
    assign hit1[g] = (syn_i == KONE);
  end

  for (genvar g = 0; g < PAIR_N; g++) begin : g_pair
    localparam logic [CHK_W-1:0] KPAIR = pow_rem(g) ^ pow_rem(g + 1);
    assign hit2[g] = (syn_i == KPAIR);
  end

  assign flip_o = hit1 | {1'b0, hit2} | {hit2, 1'b0};

  always_comb begin
    if (syn_i == '0)  fix_o = FIX_NONE;
    else if (|hit1)   fix_o = FIX_ONE;
    else if (|hit2)   fix_o = FIX_ADJ;
    else              fix_o = FIX_FAIL;
  end

  always_comb begin
    if (!$isunknown(syn_i)) begin
      assert_one_pattern_R3: assert ($onehot0({hit2, hit1}))
        else $error("more than one error pattern matched");
      assert_fail_untouched_R5: assert ((fix_o != FIX_FAIL) || (flip_o == '0))
        else $error("unrepairable word had bits flipped");
      assert_clean_untouched_R2: assert ((syn_i != '0) || (flip_o == '0))
        else $error("clean word had bits flipped");
      assert_pair_two_bits_R4: assert ((fix_o != FIX_ADJ) || ($countones(flip_o) == 2))
        else $error("pair repair did not flip two bits");
    end
  end
endmodule

// File: rtl/bch_msg_corrector.sv
module bch_msg_corrector
  import bchfix_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [1:0]        out_fix,
  output logic              out_perr,
  output logic              out_is_msg,
  output logic [OUT_W-1:0]  out_word
);
  logic              rst_q;
  logic [CODE_N-1:0] code_rx;
  logic [CHK_W-1:0]  syn;
  logic [CODE_N-1:0] flip;
  fix_e              fix_c;
  logic [CODE_N-1:0] code_fixed;

  result_t res_d, res_q;
  logic    msg_d, msg_q;
  logic    vld_d, vld_q;
  logic    load_en;

  bchfix_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  assign code_rx = in_word[WORD_W-1:1];

  bchfix_syndrome u_syn (
    .code_i (code_rx),
    .syn_o  (syn)
  );

  bchfix_locator u_loc (
    .syn_i  (syn),
    .flip_o (flip),
    .fix_o  (fix_c)
  );

  assign in_ready = 1'b1;
  assign load_en  = in_valid;

  always_comb begin
    code_fixed = code_rx ^ flip;
    res_d.data = code_fixed[CODE_N-2 -: DATA_W];
    res_d.fix  = fix_c;
    res_d.perr = ^in_word;
    msg_d      = code_fixed[CODE_N-1];
    vld_d      = in_valid;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      vld_q <= 1'b0;
      res_q <= '0;
      msg_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (load_en) begin
        res_q <= res_d;
        msg_q <= msg_d;
      end
    end
  end

  assign out_valid  = vld_q;
  assign out_data   = res_q.data;
  assign out_fix    = res_q.fix;
  assign out_perr   = res_q.perr;
  assign out_is_msg = msg_q;
  assign out_word   = res_q;

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> out_valid)
    else $error("accepted word produced no result");

  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> !out_valid)
    else $error("result without an accepted word");

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> ($stable(out_word) && $stable(out_is_msg)))
    else $error("result changed in an idle cycle");

  assert_parity_raw_R6: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> (out_perr == ^$past(in_word)))
    else $error("parity flag not taken from received word");

  assert_single_distance_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && (out_fix == 2'b10)) |->
      ($countones({out_is_msg, out_data} ^ $past(in_word[WORD_W-1:CHK_W+1])) <= 1))
    else $error("single repair changed more than one bit");

  assert_passthrough_R5: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && ((out_fix == 2'b00) || (out_fix == 2'b11))) |->
      ({out_is_msg, out_data} == $past(in_word[WORD_W-1:CHK_W+1])))
    else $error("unrepaired word was altered");
endmodule

// File: tb/bch_msg_corrector_test.sv
module bch_msg_corrector_test;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_word;
  logic        out_valid;
  logic [19:0] out_data;
  logic [1:0]  out_fix;
  logic        out_perr;
  logic        out_is_msg;
  logic [22:0] out_word;

  int total;
  int fails;
  bit done;

  localparam logic [10:0] POLY = 11'h769;

  bch_msg_corrector uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_data(out_data),
    .out_fix(out_fix), .out_perr(out_perr), .out_is_msg(out_is_msg),
    .out_word(out_word)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [9:0] rem31(input logic [30:0] c);
    logic [10:0] r;
    r = '0;
    for (int i = 30; i >= 0; i--) begin
      r = {r[9:0], c[i]};
      if (r[10]) r = r ^ POLY;
    end
    return r[9:0];
  endfunction

  function automatic logic [31:0] encode(input logic [20:0] info);
    logic [30:0] c;
    c = {info, 10'b0};
    c[9:0] = rem31(c);
    return {c, ^c};
  endfunction

  // expected {valid, is_msg, word[22:0]}
  function automatic logic [24:0] model(input logic [31:0] w);
    logic [30:0] c;
    logic [1:0]  fx;
    bit          found;
    c = w[31:1];
    found = 0;
    fx = 2'b11;
    if (rem31(c) == 10'd0) begin
      fx = 2'b00;
      found = 1;
    end
    for (int i = 0; i < 31; i++)
      if (!found && rem31(c ^ (31'd1 << i)) == 10'd0) begin
        c = c ^ (31'd1 << i);
        fx = 2'b10;
        found = 1;
      end
    for (int i = 0; i < 30; i++)
      if (!found && rem31(c ^ (31'd3 << i)) == 10'd0) begin
        c = c ^ (31'd3 << i);
        fx = 2'b01;
        found = 1;
      end
    return {1'b1, c[30], c[29:10], fx, ^w};
  endfunction

  task automatic chk(input string tag, input bit ok, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic send(input logic [31:0] w, input string tag);
    logic [24:0] exp;
    logic [24:0] got;
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    exp = model(w);
    got = {out_valid, out_is_msg, out_word};
    chk(tag, got == exp, 64'(got), 64'(exp));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL R8 watchdog expired got 0 exp 1");
    finish_run();
  end

  initial begin
    logic [31:0] w;
    logic [22:0] last_word;
    logic        last_msg;
    int          a;
    int          b;
    total = 0;
    fails = 0;
    done  = 0;
    void'($urandom(32'd20240517));
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_word  = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset", {out_valid, out_is_msg, out_word} == 25'd0,
        64'({out_valid, out_is_msg, out_word}), 64'd0);
    chk("R8 ready", in_ready == 1'b1, 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 after release", {out_valid, out_is_msg, out_word} == 25'd0,
        64'({out_valid, out_is_msg, out_word}), 64'd0);

    // R1 R2 R7 clean words of both types
    send(encode(21'h000000), "R2 clean zero");
    send(encode(21'h1FFFFF), "R7 clean all ones message");
    send(encode(21'h0ABCDE), "R7 clean address");
    send(encode(21'h1ABCDE), "R1 clean message");
    for (int k = 0; k < 20; k++) send(encode(21'($urandom)), "R2 clean random");

    // R3 every single position of bits 31:1
    for (int p = 1; p < 32; p++) send(encode(21'($urandom)) ^ (32'd1 << p), "R3 single");

    // R4 every neighbouring pair
    for (int p = 1; p < 31; p++) send(encode(21'($urandom)) ^ (32'd3 << p), "R4 pair");

    // R6 parity bit only, and a bare check-bit flip
    send(encode(21'h12345) ^ 32'd1, "R6 parity only");
    send(encode(21'h054321) ^ 32'd1 ^ (32'd1 << 5), "R6 parity plus check bit");

    // R5 two separated errors
    for (int k = 0; k < 60; k++) begin
      a = 1 + int'($urandom % 31);
      b = 1 + int'($urandom % 31);
      while (b == a || b == a + 1 || b == a - 1) b = 1 + int'($urandom % 31);
      send(encode(21'($urandom)) ^ (32'd1 << a) ^ (32'd1 << b), "R5 separated pair");
    end

    // R9 packing against separate ports
    send(encode(21'h1C0FFE) ^ (32'd1 << 17), "R9 before pack");
    chk("R9 pack", out_word == {out_data, out_fix, out_perr},
        64'(out_word), 64'({out_data, out_fix, out_perr}));

    // R11 and R8 idle cycles
    last_word = out_word;
    last_msg  = out_is_msg;
    in_valid  = 1'b0;
    in_word   = $urandom;
    @(negedge clk);
    chk("R8 idle valid", out_valid == 1'b0, 64'(out_valid), 64'd0);
    chk("R11 hold", {out_is_msg, out_word} == {last_msg, last_word},
        64'({out_is_msg, out_word}), 64'({last_msg, last_word}));
    in_word = ~in_word;
    @(negedge clk);
    chk("R11 hold second", {out_is_msg, out_word} == {last_msg, last_word},
        64'({out_is_msg, out_word}), 64'({last_msg, last_word}));

    // mixed random stream, sometimes with gaps
    for (int k = 0; k < 1500; k++) begin
      w = encode(21'($urandom));
      case ($urandom % 5)
        0: ;
        1: w = w ^ (32'd1 << ($urandom % 32));
        2: w = w ^ (32'd3 << (1 + $urandom % 30));
        3: w = $urandom;
        default: w = w ^ (32'd7 << (1 + $urandom % 29));
      endcase
      send(w, "R1 mixed");
      if ($urandom % 8 == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
        chk("R8 gap", out_valid == 1'b0, 64'(out_valid), 64'd0);
      end
    end

    in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule